// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave with Burst Address Hold

This block sits on a host bus where the upper address and the data share one set of lines. When the host raises the address strobe, the block captures the upper address from the shared lines. The low four address bits come on their own lines, which never carry data. The block joins the held upper part and the live low nibble into a 20-bit access address. That address indexes an internal word array. Read data goes back onto the shared lines, and a write strobe stores data from them.

Two bus widths are supported. In the wide mode, all sixteen shared lines carry address bits 19..4 and then data bits 15..0. In the narrow mode, only the low eight shared lines are multiplexed: they carry address bits 11..4 and data bits 7..0. Address bits 19..12 then come from a separate segment port, sampled on the same clock edge as the shared lines.

Burst code fetches work because the upper address is held. After one strobe, the host can step the low nibble through up to sixteen locations. Each access then returns the word that the current nibble selects. No new strobe is needed.

Top module: `mxb_burst_slave`

## Requirements
- R1: While reset is low, the block holds `mux_oe` at 0 and `mux_out` at 0, and the latched upper address is 0. After reset is released, a read with no strobe uses upper address 0, so `acc_addr` equals `lo_addr`.
- R2: In wide mode (`bus_wide`=1), a clock edge that samples `addr_stb` high loads `mux_in[15:0]` into `acc_addr[19:4]`.
- R3: In narrow mode (`bus_wide`=0), a clock edge that samples `addr_stb` high loads `{seg_addr, mux_in[7:0]}` into `acc_addr[19:4]`. `mux_in[15:8]` has no effect on the latched address.
- R4: `acc_addr[19:4]` changes only on an edge that samples `addr_stb` high. Across a burst, sixteen reads with only `lo_addr` changing return sixteen consecutive words of the same block.
- R5: `acc_addr[3:0]` always equals `lo_addr`. A read returns, one clock edge later, the word at the address that was current at that edge, whatever order the nibbles come in.
- R6: `mux_oe` is 1 in the cycle after an edge that samples `rd_stb_n`=0 or `fetch_stb_n`=0, together with `addr_stb`=0 and `wr_stb_n`=1. Otherwise it is 0.
- R7: A 1-to-0 transition of `wr_stb_n`, sampled while `addr_stb` is 0, stores `mux_in` at the array word selected by `acc_addr[MEM_AW-1:0]`. Holding `wr_stb_n` low stores nothing further. A fall sampled together with `addr_stb` high is ignored.
- R8: In narrow mode, a write stores `mux_in[7:0]` with the upper byte cleared. A read drives `mux_out[15:8]` as 0.
- R9: Whenever `mux_oe` is 0, `mux_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which all host signals are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide | input | 1 | 1 selects the 16-bit multiplexed mode, 0 the 8-bit one |
| addr_stb | input | 1 | Address strobe, active high |
| mux_in | input | 16 | Shared address/data lines, incoming value |
| seg_addr | input | 8 | Address bits 19..12 for narrow mode |
| lo_addr | input | 4 | Dedicated address bits 3..0 |
| rd_stb_n | input | 1 | Data read strobe, active low |
| fetch_stb_n | input | 1 | Code fetch strobe, active low |
| wr_stb_n | input | 1 | Write strobe, active low |
| mux_out | output | 16 | Value driven onto the shared lines |
| mux_oe | output | 1 | Drive enable for the shared lines |
| acc_addr | output | 20 | Assembled access address |

## Verification
The hardest situations to reach involve more than one strobe in the same cycle. These are a write edge that lands on the same clock as the address strobe, a read strobe that overlaps the address strobe or a write, and a write strobe held low while the shared lines keep changing.

The stimulus first fills the whole array through wide-mode write bursts, so every later read has a known value. Directed sequences then put these strobes in the same sampled cycle. After each one, a read brings the stored word back out on the shared lines, which shows whether anything was written. A reset is also applied in the middle of a burst, followed by a read with no new strobe.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  localparam int LANE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic {
    BUS_NARROW = 1'b0,
    BUS_WIDE   = 1'b1
  } bus_width_e;

  // a byte lane is live when it is lane 0 or when the bus is wide
  function automatic logic lane_live(input bus_width_e w, input int lane);
    return (lane == 0) || (w == BUS_WIDE);
  endfunction
endpackage

// File: rtl/mxb_addr_latch.sv
module mxb_addr_latch
  import mxb_pkg::*;
#(
  parameter int UP_W  = 16,
  parameter int SEG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_stb,
  input  bus_width_e            width,
  input  logic [UP_W-1:0]       mux_in,
  input  logic [SEG_W-1:0]      seg_addr,
  input  logic [NIB_W-1:0]      lo_addr,
  output logic [UP_W+NIB_W-1:0] full_addr
);
  localparam int MUXED_NARROW = UP_W - SEG_W;

  logic [UP_W-1:0] upper_q;
  logic [UP_W-1:0] upper_d;

  always_comb begin
    if (width == BUS_WIDE) upper_d = mux_in;
    else                   upper_d = {seg_addr, mux_in[MUXED_NARROW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        upper_q <= '0;
    else if (addr_stb) upper_q <= upper_d;
  end

  assign full_addr = {upper_q, lo_addr};
endmodule

// File: rtl/mxb_strobe.sv
module mxb_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_stb,
  input  logic rd_stb_n,
  input  logic fetch_stb_n,
  input  logic wr_stb_n,
  output logic rd_act,
  output logic wr_pulse
);
  logic wr_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b1;
    else        wr_prev_q <= wr_stb_n;
  end

  assign rd_act   = (~rd_stb_n | ~fetch_stb_n) & ~addr_stb & wr_stb_n;
  assign wr_pulse = wr_prev_q & ~wr_stb_n & ~addr_stb;
endmodule

// File: rtl/mxb_array.sv
module mxb_array #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
  end

  assign rdata = store[idx];
endmodule

// File: rtl/mxb_drive.sv
module mxb_drive
  import mxb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  bus_width_e    width,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] mux_out,
  output logic          mux_oe
);
  localparam int LANES = DW / LANE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mux_oe <= 1'b0;
    else        mux_oe <= rd_act;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          lane_q <= '0;
      else if (rd_act && lane_live(width, l)) lane_q <= rdata[l*LANE_W +: LANE_W];
      else                                 lane_q <= '0;
    end
    assign mux_out[l*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/mxb_burst_slave.sv
module mxb_burst_slave
  import mxb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 8,
  parameter int MEM_AW = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wide,
  input  logic                    addr_stb,
  input  logic [DATA_W-1:0]       mux_in,
  input  logic [SEG_W-1:0]        seg_addr,
  input  logic [NIB_W-1:0]        lo_addr,
  input  logic                    rd_stb_n,
  input  logic                    fetch_stb_n,
  input  logic                    wr_stb_n,
  output logic [DATA_W-1:0]       mux_out,
  output logic                    mux_oe,
  output logic [DATA_W+NIB_W-1:0] acc_addr
);
  localparam int ADDR_W = DATA_W + NIB_W;
  localparam int LANES  = DATA_W / LANE_W;

  bus_width_e        width;
  logic              rd_act;
  logic              wr_pulse;
  logic [ADDR_W-1:0] full_addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  assign width = bus_width_e'(bus_wide);

  mxb_addr_latch #(.UP_W(DATA_W), .SEG_W(SEG_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_stb  (addr_stb),
    .width     (width),
    .mux_in    (mux_in),
    .seg_addr  (seg_addr),
    .lo_addr   (lo_addr),
    .full_addr (full_addr)
  );

  mxb_strobe u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_stb    (addr_stb),
    .rd_stb_n    (rd_stb_n),
    .fetch_stb_n (fetch_stb_n),
    .wr_stb_n    (wr_stb_n),
    .rd_act      (rd_act),
    .wr_pulse    (wr_pulse)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_wlane
    assign wdata[l*LANE_W +: LANE_W] =
      lane_live(width, l) ? mux_in[l*LANE_W +: LANE_W] : '0;
  end

  mxb_array #(.AW(MEM_AW), .DW(DATA_W)) u_array (
    .clk   (clk),
    .we    (wr_pulse),
    .idx   (full_addr[MEM_AW-1:0]),
    .wdata (wdata),
    .rdata (rdata)
  );

  mxb_drive #(.DW(DATA_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_act  (rd_act),
    .width   (width),
    .rdata   (rdata),
    .mux_out (mux_out),
    .mux_oe  (mux_oe)
  );

  assign acc_addr = full_addr;
endmodule

// File: rtl/mxb_burst_slave_chk.sv
module mxb_burst_slave_chk #(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 8,
  parameter int NIB_W  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wide,
  input logic                    addr_stb,
  input logic [DATA_W-1:0]       mux_in,
  input logic [SEG_W-1:0]        seg_addr,
  input logic [NIB_W-1:0]        lo_addr,
  input logic                    rd_stb_n,
  input logic                    fetch_stb_n,
  input logic                    wr_stb_n,
  input logic [DATA_W-1:0]       mux_out,
  input logic                    mux_oe,
  input logic [DATA_W+NIB_W-1:0] acc_addr
);
  localparam int MUXED_NARROW = DATA_W - SEG_W;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mux_oe && mux_out == '0));

  assert_wide_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && bus_wide) |=> acc_addr[DATA_W+NIB_W-1:NIB_W] == $past(mux_in));

  assert_narrow_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && !bus_wide) |=> acc_addr[DATA_W+NIB_W-1:NIB_W] ==
      {$past(seg_addr), $past(mux_in[MUXED_NARROW-1:0])});

  assert_upper_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> $stable(acc_addr[DATA_W+NIB_W-1:NIB_W]));

  assert_low_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr[NIB_W-1:0] == lo_addr);

  assert_drive_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_stb_n || !fetch_stb_n) && !addr_stb && wr_stb_n) |=> mux_oe);

  assert_drive_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb || !wr_stb_n || (rd_stb_n && fetch_stb_n)) |=> !mux_oe);

  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_oe && !$past(bus_wide)) |-> mux_out[DATA_W-1:LANE_W] == '0);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_oe |-> mux_out == '0);
endmodule

bind mxb_burst_slave mxb_burst_slave_chk #(
  .DATA_W (DATA_W),
  .SEG_W  (SEG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wide    (bus_wide),
  .addr_stb    (addr_stb),
  .mux_in      (mux_in),
  .seg_addr    (seg_addr),
  .lo_addr     (lo_addr),
  .rd_stb_n    (rd_stb_n),
  .fetch_stb_n (fetch_stb_n),
  .wr_stb_n    (wr_stb_n),
  .mux_out     (mux_out),
  .mux_oe      (mux_oe),
  .acc_addr    (acc_addr)
);

// File: tb/test_mxb_burst_slave.sv
module test_mxb_burst_slave;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 10;
  localparam int DEPTH      = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_wide = 1'b1;
  logic        addr_stb = 1'b0;
  logic [15:0] mux_in = '0;
  logic [7:0]  seg_addr = '0;
  logic [3:0]  lo_addr = '0;
  logic        rd_stb_n = 1'b1;
  logic        fetch_stb_n = 1'b1;
  logic        wr_stb_n = 1'b1;
  logic [15:0] mux_out;
  logic        mux_oe;
  logic [19:0] acc_addr;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  int m_mem [DEPTH];
  int m_upper;
  int m_out;
  bit m_oe;
  bit m_wr_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxb_burst_slave #(.MEM_AW(MEM_AW)) i_mxb_burst_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wide    (bus_wide),
    .addr_stb    (addr_stb),
    .mux_in      (mux_in),
    .seg_addr    (seg_addr),
    .lo_addr     (lo_addr),
    .rd_stb_n    (rd_stb_n),
    .fetch_stb_n (fetch_stb_n),
    .wr_stb_n    (wr_stb_n),
    .mux_out     (mux_out),
    .mux_oe      (mux_oe),
    .acc_addr    (acc_addr)
  );

  function automatic int pat(int i);
    return (i * 40503 + 4660) & 16'hFFFF;
  endfunction

  // behavioural reference model, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_upper = 0; m_oe = 0; m_out = 0; m_wr_prev = 1;
    end else begin
      int idx;
      bit rd;
      rd  = (!rd_stb_n || !fetch_stb_n) && !addr_stb && wr_stb_n;
      idx = ((m_upper * 16) + int'(lo_addr)) % DEPTH;
      m_oe  = rd;
      m_out = rd ? (bus_wide ? m_mem[idx] : (m_mem[idx] & 255)) : 0;
      if (m_wr_prev && !wr_stb_n && !addr_stb)
        m_mem[idx] = bus_wide ? int'(mux_in) : int'(mux_in[7:0]);
      if (addr_stb)
        m_upper = bus_wide ? int'(mux_in) : int'({seg_addr, mux_in[7:0]});
      m_wr_prev = wr_stb_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (mux_oe !== m_oe || mux_out !== 16'(m_out) ||
          acc_addr !== 20'((m_upper * 16) + int'(lo_addr))) begin
        errors++;
        $display("FAIL %s: oe=%0b out=%h addr=%h expected oe=%0b out=%h addr=%h",
                 cur_req, mux_oe, mux_out, acc_addr, m_oe, 16'(m_out),
                 20'((m_upper * 16) + int'(lo_addr)));
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic latch_wide(int up);
    @(negedge clk);
    bus_wide = 1'b1; addr_stb = 1'b1; mux_in = 16'(up);
    @(negedge clk);
    addr_stb = 1'b0; mux_in = '0;
  endtask

  task automatic latch_narrow(int seg, int mid, int junk);
    @(negedge clk);
    bus_wide = 1'b0; addr_stb = 1'b1; seg_addr = 8'(seg);
    mux_in = {8'(junk), 8'(mid)};
    @(negedge clk);
    addr_stb = 1'b0; mux_in = '0;
  endtask

  task automatic write_at(int nib, int data);
    @(negedge clk);
    lo_addr = 4'(nib); mux_in = 16'(data); wr_stb_n = 1'b0;
    @(negedge clk);
    wr_stb_n = 1'b1;
  endtask

  // reads 16 nibbles in order (k*stride)%16, checks against the fill pattern
  task automatic burst_read(string tag, bit fetch, int up, int stride);
    int prev;
    @(negedge clk);
    if (fetch) fetch_stb_n = 1'b0; else rd_stb_n = 1'b0;
    lo_addr = 4'd0; prev = 0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk(tag, 32'(mux_out), 32'(pat((up * 16 + prev) % DEPTH)));
      if (k < 16) begin
        prev = (k * stride) % 16;
        lo_addr = 4'(prev);
      end
    end
    rd_stb_n = 1'b1; fetch_stb_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    foreach (m_mem[i]) m_mem[i] = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 32'(mux_oe), 0);
    chk("R1", 32'(mux_out), 0);
    chk("R1", 32'(acc_addr), 0);
    rst_n = 1'b1;

    // fill the array through wide write bursts
    cur_req = "R7";
    for (int u = 0; u < DEPTH / 16; u++) begin
      latch_wide(u);
      for (int n = 0; n < 16; n++) write_at(n, pat(u * 16 + n));
    end

    cur_req = "R4";
    latch_wide(16'h0023);
    burst_read("R4", 1'b0, 16'h0023, 1);

    cur_req = "R5";
    latch_wide(16'h0011);
    burst_read("R5", 1'b1, 16'h0011, 7);

    cur_req = "R2";
    latch_wide(16'hA5C7);
    @(negedge clk); lo_addr = 4'd9;
    chk("R2", 32'(acc_addr), 32'h000A5C79);
    rd_stb_n = 1'b0;
    @(negedge clk);
    chk("R2", 32'(mux_out), 32'(pat(20'hA5C79 % DEPTH)));
    rd_stb_n = 1'b1;

    cur_req = "R3";
    latch_narrow(8'h3C, 8'h2E, 8'hF1);
    chk("R3", 32'(acc_addr[19:4]), 32'h3C2E);
    @(negedge clk); lo_addr = 4'd4; rd_stb_n = 1'b0;
    @(negedge clk);
    chk("R3", 32'(mux_out), 32'(pat(20'h3C2E4 % DEPTH) & 255));
    chk("R8", 32'(mux_out[15:8]), 0);
    rd_stb_n = 1'b1;

    cur_req = "R8";
    latch_narrow(8'h00, 8'h3F, 8'h77);
    write_at(5, 16'hBEEF);
    latch_wide(16'h003F);
    @(negedge clk); lo_addr = 4'd5; rd_stb_n = 1'b0;
    @(negedge clk);
    chk("R8", 32'(mux_out), 32'h00EF);
    rd_stb_n = 1'b1;

    cur_req = "R7";
    @(negedge clk); lo_addr = 4'd6; mux_in = 16'h1111; wr_stb_n = 1'b0;
    @(negedge clk); mux_in = 16'h2222;
    @(negedge clk); mux_in = 16'h3333;
    @(negedge clk); wr_stb_n = 1'b1;
    @(negedge clk); addr_stb = 1'b1; mux_in = 16'h003F; lo_addr = 4'd7; wr_stb_n = 1'b0;
    @(negedge clk); addr_stb = 1'b0; wr_stb_n = 1'b1; mux_in = '0;
    @(negedge clk); lo_addr = 4'd6; rd_stb_n = 1'b0;
    @(negedge clk); chk("R7", 32'(mux_out), 32'h1111); lo_addr = 4'd7;
    @(negedge clk); chk("R7", 32'(mux_out), 32'(pat(16'h3F7 % DEPTH)));
    rd_stb_n = 1'b1;

    cur_req = "R6";
    @(negedge clk); addr_stb = 1'b1; mux_in = 16'h0023; rd_stb_n = 1'b0; lo_addr = 4'd2;
    @(negedge clk); chk("R6", 32'(mux_oe), 0); addr_stb = 1'b0; mux_in = '0;
    @(negedge clk); chk("R6", 32'(mux_oe), 1);
    chk("R6", 32'(mux_out), 32'(pat(16'h232)));
    lo_addr = 4'd15; mux_in = 16'hCAFE; wr_stb_n = 1'b0;
    @(negedge clk); chk("R6", 32'(mux_oe), 0); wr_stb_n = 1'b1; rd_stb_n = 1'b1;

    cur_req = "R9";
    @(negedge clk);
    chk("R9", 32'(mux_oe), 0);
    chk("R9", 32'(mux_out), 0);

    cur_req = "R1";
    latch_wide(16'h0030);
    @(negedge clk); rd_stb_n = 1'b0; lo_addr = 4'd3;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 32'(mux_oe), 0);
    chk("R1", 32'(mux_out), 0);
    rst_n = 1'b1; lo_addr = 4'd5;
    @(negedge clk);
    chk("R1", 32'(acc_addr), 5);
    chk("R1", 32'(mux_out), 32'(pat(5)));
    rd_stb_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule